// File: doc/BRIEF.md
# EPROM Word Program-and-Verify Sequencer

This block writes one 16-bit word into an on-chip EPROM array using an adaptive pulse-then-check loop. A host presents the target location as two bytes, the word to store as two bytes, and a mode bit that selects between an ordinary user location and a configuration location. It then strobes `start`. The sequencer first reads the location and refuses to touch it unless every bit is still erased. An erased cell reads as 1, so a blank word is all ones.

Once the location is known to be blank, the block applies program pulses one at a time and reads the word back after each pulse, until the read matches. It remembers how many pulses that took and then adds three times as many extra pulses to build margin. Last, it reads the word twice more: once with the external supply controller set to the low margin and once with it set to the high margin. Before each of these two reads it raises a margin request so the supply has a cycle to settle.

The array read path has a one-cycle latency: a value requested in one cycle is presented on `rd_data` in the next. The supply switching itself lies outside this block.

Top module: `eprom_pgm_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `pulse_en`, `verify_req`, `margin_en` and `margin_hi` are all low.
- R2: On a `start` seen while idle, the block captures `{addr_hi,addr_lo}` on `mem_addr` and `{data_hi,data_lo}` on `mem_wdata`. `busy` is high from the next cycle until the cycle in which `done` is high. A `start` seen while busy changes nothing, neither the captured address nor the run.
- R3: The first action of every run is a single nominal read of the location, made before any pulse. If that read is not 16'hFFFF, the run ends with status 2'b10, having applied no pulse.
- R4: Each program pulse holds `pulse_en` high for exactly `USR_PULSE_CYC` cycles in user mode (`cfg_mode`=0). In configuration mode (`cfg_mode`=1) it holds it for `CFG_PULSE_US`×`CYC_PER_US` cycles, which is 100 µs.
- R5: During the counting phase, every pulse is followed by one nominal read, with `margin_en` low, that compares all 16 bits with `mem_wdata`. The pulse tally restarts at zero on each new run. A pulse and a read request are never active in the same cycle.
- R6: After the first matching read that follows n pulses, the block applies exactly 3×n extra pulses, each separated by one low cycle. A passing run lasts 2 + n(W+2) + 3nW + (3n−1) + 6 busy cycles, where W is the pulse width.
- R7: If n reaches `MAX_PULSES` (25) without a matching read, the run ends with status 2'b01 after exactly 25 pulses. It applies no extra pulse and makes no margin read.
- R8: `margin_en` rises one cycle before each margin read and stays high through it. The low-margin read (`margin_hi`=0) comes first and the high-margin read (`margin_hi`=1) second. A mismatch at low margin ends with status 2'b01 and skips the high read. The run passes (2'b00) only if both reads match.
- R9: `done` is high for exactly one cycle when a run ends, with `status` valid in that cycle. The encodings are 2'b00 pass, 2'b01 fail and 2'b10 not blank; the value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin programming one word |
| cfg_mode | input | 1 | 1 = configuration location (fixed 100 µs pulse), 0 = user location |
| addr_hi | input | 8 | Target address, upper byte |
| addr_lo | input | 8 | Target address, lower byte |
| data_hi | input | 8 | Word to program, upper byte |
| data_lo | input | 8 | Word to program, lower byte |
| rd_data | input | 16 | Word read from the array, valid the cycle after `verify_req` |
| mem_addr | output | 16 | Captured target address |
| mem_wdata | output | 16 | Captured word being programmed |
| pulse_en | output | 1 | Program pulse active |
| verify_req | output | 1 | Read request to the array |
| margin_en | output | 1 | Margin read phase; supply controller must move off nominal |
| margin_hi | output | 1 | Selects high (1) or low (0) supply margin while `margin_en` is high |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| status | output | 2 | Result code, valid with `done` |

## Verification
The assertions assume that `rd_data` is driven by a read path with exactly one cycle of latency. They also assume the host holds the byte buses steady on the cycle it strobes `start`. The bench satisfies both by modelling the array as a register loaded on each `verify_req` and by driving all inputs a moment after the rising edge. The array model makes a word read as programmed only after a chosen number of pulses. It uses separate thresholds for the nominal, low-margin and high-margin reads, so every exit path is reached with counts the bench derives from those thresholds.

// File: rtl/eprom_pgm_pkg.sv
`timescale 1ns/1ps
// Shared types for the EPROM program-and-verify sequencer.
// Assumes: nothing beyond the encodings listed here.
package eprom_pgm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLANK_REQ,
        ST_BLANK_CHK,
        ST_PULSE,
        ST_VER_REQ,
        ST_VER_CHK,
        ST_XPULSE,
        ST_XGAP,
        ST_MLO_SET,
        ST_MLO_REQ,
        ST_MLO_CHK,
        ST_MHI_SET,
        ST_MHI_REQ,
        ST_MHI_CHK
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_PASS     = 2'b00,
        RES_FAIL     = 2'b01,
        RES_NOTBLANK = 2'b10
    } pgm_result_t;

endpackage

// File: rtl/eprom_pulse_timer.sv
`timescale 1ns/1ps
// Program pulse timer: holds active high for exactly `width` cycles after start.
// Assumes: width >= 1 and start is not raised while active.
module eprom_pulse_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    output logic          active,
    output logic          last
);

    logic [CW-1:0] remain;

    // Load the width on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= width;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
    assign last   = (remain == CW'(1));

endmodule

// File: rtl/eprom_pulse_tally.sv
`timescale 1ns/1ps
// Pulse bookkeeping: counts counting-phase pulses and margin pulses.
// Assumes: clear comes only at run start; extra_clr comes after the counting phase.
module eprom_pulse_tally #(
    parameter int MAX_PULSES = 25,
    parameter int EXTRA_MULT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic main_inc,
    input  logic extra_clr,
    input  logic extra_inc,
    output logic at_cap,
    output logic extra_last
);

    localparam int NW = $clog2(MAX_PULSES + 1);
    localparam int XW = $clog2(EXTRA_MULT * MAX_PULSES + 2);

    logic [NW-1:0] main_cnt;
    logic [XW-1:0] extra_cnt;
    logic [XW-1:0] extra_goal;

    // Counting-phase pulse tally, zeroed when a new address is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            main_cnt <= '0;
        else if (main_inc)
            main_cnt <= main_cnt + 1'b1;
    end

    // Margin pulse tally.
    always_ff @(posedge clk) begin
        if (!rst_n || extra_clr)
            extra_cnt <= '0;
        else if (extra_inc)
            extra_cnt <= extra_cnt + 1'b1;
    end

    assign extra_goal = XW'(main_cnt) * XW'(EXTRA_MULT);
    assign at_cap     = (main_cnt == NW'(MAX_PULSES));
    assign extra_last = ((extra_cnt + 1'b1) == extra_goal);

endmodule

// File: rtl/eprom_word_cmp.sv
`timescale 1ns/1ps
// Read-back comparator: blank detection and full-width match.
// Assumes: an erased bit reads as 1.
module eprom_word_cmp #(
    parameter int WW = 16
) (
    input  logic [WW-1:0] rd_word,
    input  logic [WW-1:0] exp_word,
    output logic          is_blank,
    output logic          match
);

    assign is_blank = &rd_word;
    assign match    = (rd_word == exp_word);

endmodule

// File: rtl/eprom_pgm_seq.sv
`timescale 1ns/1ps
// EPROM word program-and-verify sequencer (top).
// Blank check, adaptive pulse/verify loop, 3x margin pulses, dual-margin verify.
// Assumes: rd_data is valid one cycle after verify_req; byte buses stable with start.
module eprom_pgm_seq #(
    parameter int BYTE_W        = 8,
    parameter int USR_PULSE_CYC = 2000,
    parameter int CYC_PER_US    = 20,
    parameter int CFG_PULSE_US  = 100,
    parameter int MAX_PULSES    = 25,
    parameter int EXTRA_MULT    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cfg_mode,
    input  logic [BYTE_W-1:0]   addr_hi,
    input  logic [BYTE_W-1:0]   addr_lo,
    input  logic [BYTE_W-1:0]   data_hi,
    input  logic [BYTE_W-1:0]   data_lo,
    input  logic [2*BYTE_W-1:0] rd_data,
    output logic [2*BYTE_W-1:0] mem_addr,
    output logic [2*BYTE_W-1:0] mem_wdata,
    output logic                pulse_en,
    output logic                verify_req,
    output logic                margin_en,
    output logic                margin_hi,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status
);
    import eprom_pgm_pkg::*;

    localparam int WORD_W        = 2 * BYTE_W;
    localparam int CFG_PULSE_CYC = CFG_PULSE_US * CYC_PER_US;
    localparam int MAX_W         = (CFG_PULSE_CYC > USR_PULSE_CYC) ? CFG_PULSE_CYC : USR_PULSE_CYC;
    localparam int TW            = $clog2(MAX_W + 1);

    seq_state_t  st, nxt;
    logic        cfg_q;
    logic [TW-1:0] width_sel;
    logic        tmr_start, tmr_active, tmr_last;
    logic        main_inc, extra_inc, extra_clr, tally_clr;
    logic        at_cap, extra_last;
    logic        is_blank, match;
    logic        fin;
    pgm_result_t fin_code;

    eprom_pulse_timer #(.CW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .width  (width_sel),
        .active (tmr_active),
        .last   (tmr_last)
    );

    eprom_pulse_tally #(.MAX_PULSES(MAX_PULSES), .EXTRA_MULT(EXTRA_MULT)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tally_clr),
        .main_inc   (main_inc),
        .extra_clr  (extra_clr),
        .extra_inc  (extra_inc),
        .at_cap     (at_cap),
        .extra_last (extra_last)
    );

    eprom_word_cmp #(.WW(WORD_W)) u_cmp (
        .rd_word  (rd_data),
        .exp_word (mem_wdata),
        .is_blank (is_blank),
        .match    (match)
    );

    assign width_sel = cfg_q ? TW'(CFG_PULSE_CYC) : TW'(USR_PULSE_CYC);
    assign tally_clr = (st == ST_IDLE) && start;

    // Next-state and control strobes of the sequencer.
    always_comb begin
        nxt       = st;
        tmr_start = 1'b0;
        main_inc  = 1'b0;
        extra_inc = 1'b0;
        extra_clr = 1'b0;
        fin       = 1'b0;
        fin_code  = RES_PASS;
        unique case (st)
            ST_IDLE:      if (start) nxt = ST_BLANK_REQ;
            ST_BLANK_REQ: nxt = ST_BLANK_CHK;
            ST_BLANK_CHK: begin
                if (!is_blank) begin
                    fin      = 1'b1;
                    fin_code = RES_NOTBLANK;
                    nxt      = ST_IDLE;
                end else begin
                    tmr_start = 1'b1;
                    nxt       = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_last) begin
                    main_inc = 1'b1;
                    nxt      = ST_VER_REQ;
                end
            end
            ST_VER_REQ:   nxt = ST_VER_CHK;
            ST_VER_CHK: begin
                if (match) begin
                    extra_clr = 1'b1;
                    tmr_start = 1'b1;
                    nxt       = ST_XPULSE;
                end else if (at_cap) begin
                    fin      = 1'b1;
                    fin_code = RES_FAIL;
                    nxt      = ST_IDLE;
                end else begin
                    tmr_start = 1'b1;
                    nxt       = ST_PULSE;
                end
            end
            ST_XPULSE: begin
                if (tmr_last) begin
                    extra_inc = 1'b1;
                    nxt       = extra_last ? ST_MLO_SET : ST_XGAP;
                end
            end
            ST_XGAP: begin
                tmr_start = 1'b1;
                nxt       = ST_XPULSE;
            end
            ST_MLO_SET:   nxt = ST_MLO_REQ;
            ST_MLO_REQ:   nxt = ST_MLO_CHK;
            ST_MLO_CHK: begin
                if (match) begin
                    nxt = ST_MHI_SET;
                end else begin
                    fin      = 1'b1;
                    fin_code = RES_FAIL;
                    nxt      = ST_IDLE;
                end
            end
            ST_MHI_SET:   nxt = ST_MHI_REQ;
            ST_MHI_REQ:   nxt = ST_MHI_CHK;
            ST_MHI_CHK: begin
                fin      = 1'b1;
                fin_code = match ? RES_PASS : RES_FAIL;
                nxt      = ST_IDLE;
            end
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // Capture address, data and mode when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            cfg_q     <= 1'b0;
        end else if (tally_clr) begin
            mem_addr  <= {addr_hi, addr_lo};
            mem_wdata <= {data_hi, data_lo};
            cfg_q     <= cfg_mode;
        end
    end

    // End-of-run strobe and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            status <= RES_PASS;
        end else begin
            done <= fin;
            if (fin)
                status <= fin_code;
        end
    end

    assign pulse_en   = tmr_active;
    assign verify_req = (st == ST_BLANK_REQ) || (st == ST_VER_REQ) ||
                        (st == ST_MLO_REQ)   || (st == ST_MHI_REQ);
    assign margin_hi  = (st == ST_MHI_SET) || (st == ST_MHI_REQ) || (st == ST_MHI_CHK);
    assign margin_en  = margin_hi ||
                        (st == ST_MLO_SET) || (st == ST_MLO_REQ) || (st == ST_MLO_CHK);
    assign busy       = (st != ST_IDLE);

endmodule

// File: rtl/eprom_pgm_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for eprom_pgm_seq, attached by bind.
// Assumes: it observes only the top-level ports.
module eprom_pgm_seq_chk #(
    parameter int MAX_PULSES = 25,
    parameter int EXTRA_MULT = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [1:0]  status,
    input logic        pulse_en,
    input logic        verify_req,
    input logic        margin_en,
    input logic        margin_hi,
    input logic [15:0] mem_addr
);

    localparam int LIMIT = (EXTRA_MULT + 1) * MAX_PULSES;

    logic       pe_q;
    int unsigned pulses_run;
    int unsigned reads_run;

    // Per-run counts of pulses and read requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q       <= 1'b0;
            pulses_run <= 0;
            reads_run  <= 0;
        end else begin
            pe_q <= pulse_en;
            if (start && !busy) begin
                pulses_run <= 0;
                reads_run  <= 0;
            end else begin
                if (pulse_en && !pe_q) pulses_run <= pulses_run + 1;
                if (verify_req)        reads_run  <= reads_run + 1;
            end
        end
    end

    // R5
    pulse_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_en && verify_req));

    // R5
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req |=> !verify_req);

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R3
    blank_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && !pe_q) |-> (reads_run != 0));

    // R6
    pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_run <= LIMIT);

    // R8
    margin_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_req && margin_en) |-> ($past(margin_en) && $stable(margin_hi)));

    // R8
    margin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(margin_hi) |-> $past(margin_en));

    // R9
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && status != 2'b11));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind eprom_pgm_seq eprom_pgm_seq_chk #(
    .MAX_PULSES (MAX_PULSES),
    .EXTRA_MULT (EXTRA_MULT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .pulse_en   (pulse_en),
    .verify_req (verify_req),
    .margin_en  (margin_en),
    .margin_hi  (margin_hi),
    .mem_addr   (mem_addr)
);

// File: tb/eprom_pgm_seq_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps pulse-to-program thresholds in both modes.
module eprom_pgm_seq_bench;

    localparam int USR_W  = 3;
    localparam int CPU    = 1;
    localparam int CFG_US = 100;
    localparam int CFG_W  = CFG_US * CPU;
    localparam int CAP    = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [7:0]  addr_hi = '0, addr_lo = '0, data_hi = '0, data_lo = '0;
    logic [15:0] rd_data = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        pulse_en, verify_req, margin_en, margin_hi, busy, done;
    logic [1:0]  status;

    eprom_pgm_seq #(
        .BYTE_W(8), .USR_PULSE_CYC(USR_W), .CYC_PER_US(CPU),
        .CFG_PULSE_US(CFG_US), .MAX_PULSES(CAP), .EXTRA_MULT(3)
    ) u_eprom_pgm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .addr_hi(addr_hi), .addr_lo(addr_lo), .data_hi(data_hi), .data_lo(data_lo),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pulse_en(pulse_en), .verify_req(verify_req), .margin_en(margin_en),
        .margin_hi(margin_hi), .busy(busy), .done(done), .status(status)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // array model settings
    logic [15:0] m_init = 16'hFFFF;
    logic [15:0] m_data = 16'h0000;
    int m_kn = 1, m_kl = 1, m_kh = 1;
    int cur_w = USR_W;

    // monitor results
    int mon_pulses = 0, mon_nom = 0, mon_lo = 0, mon_hi = 0, mon_busy = 0;
    int mon_badw = 0, mon_order = 0, mon_first = -1, mon_run = 0, mon_gapbad = 0, mon_gap = 0;
    logic pe_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Observe outputs mid-cycle and accumulate per-run counts.
    always @(negedge clk) begin
        if (start && !busy) begin
            mon_pulses = 0; mon_nom = 0; mon_lo = 0; mon_hi = 0; mon_busy = 0;
            mon_badw = 0; mon_order = 0; mon_first = -1; mon_run = 0;
            mon_gapbad = 0; mon_gap = 0;
        end else begin
            if (pulse_en && !pe_prev) begin
                if (mon_pulses > 0 && mon_lo == 0 && mon_gap == 0) mon_gapbad++;
                mon_pulses++;
                mon_run = 1;
            end else if (pulse_en) begin
                mon_run++;
            end
            if (!pulse_en && pe_prev && mon_run != cur_w) mon_badw++;
            if (!pulse_en) mon_gap++; else mon_gap = 0;
            if (verify_req) begin
                if (mon_first < 0) mon_first = mon_pulses;
                if (!margin_en) mon_nom++;
                else if (margin_hi) begin
                    mon_hi++;
                    if (mon_lo == 0) mon_order++;
                end else mon_lo++;
            end
            if (busy) mon_busy++;
        end
        pe_prev = pulse_en;
    end

    // Array model: one-cycle read; word reads programmed after a threshold of pulses.
    always @(posedge clk) begin
        if (verify_req) begin
            if (!margin_en)
                rd_data <= (mon_pulses >= m_kn) ? (m_init & m_data) : m_init;
            else if (!margin_hi)
                rd_data <= (mon_pulses >= m_kl) ? (m_init & m_data) : m_init;
            else
                rd_data <= (mon_pulses >= m_kh) ? (m_init & m_data) : m_init;
        end
    end

    function automatic int pass_busy(input int k, input int w);
        return 2 + k * (w + 2) + 3 * k * w + (3 * k - 1) + 6;
    endfunction

    task automatic run_op(input string req, input logic cfg, input logic [15:0] addr,
                          input logic [15:0] data, input logic [15:0] init,
                          input int kn, input int kl, input int kh,
                          input int es, input int ep, input int enom,
                          input int elo, input int ehi, input int ebusy, input bit poke);
        int cyc;
        m_init = init; m_data = data; m_kn = kn; m_kl = kl; m_kh = kh;
        cur_w = cfg ? CFG_W : USR_W;
        @(posedge clk); #1;
        start = 1'b1; cfg_mode = cfg;
        {addr_hi, addr_lo} = addr; {data_hi, data_lo} = data;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 7) begin
                start = 1'b1; addr_hi = ~addr[15:8]; data_lo = ~data[7:0];
            end else if (poke && cyc == 8) begin
                start = 1'b0;
            end
        end
        chk(cyc < 20000, {req, " watchdog"}, cyc, 20000);
        chk(status == 2'(es), {req, " status"}, status, es);
        chk(mem_addr == addr, "R2 captured address", mem_addr, addr);
        chk(mem_wdata == data, "R2 captured data", mem_wdata, data);
        chk(mon_busy == ebusy, {req, " R2 busy length"}, mon_busy, ebusy);
        chk(mon_pulses == ep, {req, " R6 pulse total"}, mon_pulses, ep);
        chk(mon_nom == enom, {req, " R5 nominal reads"}, mon_nom, enom);
        chk(mon_lo == elo, {req, " R8 low margin reads"}, mon_lo, elo);
        chk(mon_hi == ehi, {req, " R8 high margin reads"}, mon_hi, ehi);
        chk(mon_order == 0, "R8 low before high", mon_order, 0);
        chk(mon_badw == 0, {req, " R4 pulse width"}, mon_badw, 0);
        chk(mon_first == 0, "R3 read before first pulse", mon_first, 0);
        chk(mon_gapbad == 0, "R6 low cycle between pulses", mon_gapbad, 0);
        @(negedge clk);
        chk(!done && !busy, "R9 done one cycle", done, 0);
        {addr_hi, addr_lo, data_hi, data_lo} = '0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pulse_en && !verify_req && !margin_en && !margin_hi,
            "R1 reset outputs", {busy, done, pulse_en, verify_req, margin_en, margin_hi}, 0);

        // R5 R6 R8: user-mode sweep of pulses-to-program
        for (int k = 1; k <= 6; k++) begin
            logic [15:0] d;
            d = 16'hA5C3 ^ 16'(k * 16'h1111);
            run_op("R6 user pass", 1'b0, 16'(16'h0100 + k), d, 16'hFFFF,
                   k, 4 * k, 4 * k, 0, 4 * k, 1 + k, 1, 1, pass_busy(k, USR_W), 1'b0);
        end
        // R4: configuration mode, 100 us pulses
        for (int k = 1; k <= 2; k++) begin
            run_op("R4 cfg pass", 1'b1, 16'hFE00, 16'h7FAF, 16'hFFFF,
                   k, 4 * k, 4 * k, 0, 4 * k, 1 + k, 1, 1, pass_busy(k, CFG_W), 1'b0);
        end
        // R7: never programs, stops at the cap
        run_op("R7 cap fail", 1'b0, 16'h0222, 16'h1234, 16'hFFFF,
               30, 1, 1, 1, CAP, CAP + 1, 0, 0, 2 + CAP * (USR_W + 2), 1'b0);
        // R7: passes exactly on the last allowed pulse
        run_op("R7 pass at cap", 1'b0, 16'h0333, 16'h0F0F, 16'hFFFF,
               CAP, 4 * CAP, 4 * CAP, 0, 4 * CAP, CAP + 1, 1, 1, pass_busy(CAP, USR_W), 1'b0);
        // R3: location not blank
        run_op("R3 not blank", 1'b0, 16'h0444, 16'h0000, 16'h7FFF,
               1, 1, 1, 2, 0, 1, 0, 0, 2, 1'b0);
        // R8: low-margin read fails, high read skipped
        run_op("R8 low margin fail", 1'b0, 16'h0555, 16'h00FF, 16'hFFFF,
               2, 9, 1, 1, 8, 3, 1, 0, pass_busy(2, USR_W) - 3, 1'b0);
        // R8: high-margin read fails
        run_op("R8 high margin fail", 1'b0, 16'h0666, 16'hFF00, 16'hFFFF,
               3, 12, 13, 1, 12, 4, 1, 1, pass_busy(3, USR_W), 1'b0);
        // R2: start while busy is ignored
        run_op("R2 start ignored", 1'b0, 16'h0777, 16'h5A5A, 16'hFFFF,
               2, 8, 8, 0, 8, 3, 1, 1, pass_busy(2, USR_W), 1'b1);
        // R5: tally restarts for a new run
        run_op("R5 fresh tally", 1'b0, 16'h0888, 16'hC3C3, 16'hFFFF,
               1, 4, 4, 0, 4, 2, 1, 1, pass_busy(1, USR_W), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Global watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule